// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block carries software interrupts between up to eight processors. A processor raises one by presenting a 32-bit request word together with its own number. The block works out which processors are targeted and records the requester as a source in each target's bitmap for that interrupt number. Each (target, interrupt) pair owns one bitmap with one bit per possible source processor. The pair reads as pending while any bit of its bitmap is set.

A target takes interrupts one at a time through the acknowledge port. Each acknowledge names the lowest-numbered source still recorded, removes only that source, and returns the interrupt number with the source number packed above it. Software can also OR bits into a bitmap or strip bits from it directly, and any bitmap can be read back combinationally.

The request, acknowledge and bitmap-write inputs are single-beat valid strobes. There is no ready signal. The block accepts one beat on each of the three paths in every cycle, so it never back-pressures a requester. The acknowledge result appears as a one-cycle valid pulse with no ready. The consumer must take it in the cycle it is shown.

Top module: `sgi_dispatch`

## Requirements
- R1: Request word fields: bits 9:0 carry the interrupt number, bits 23:16 a target list, and bits 25:24 a filter. The filter selects the targets. Filter 0 targets the listed processors. Filter 1 targets every processor except the requester. Filter 2 targets only the requester. Filter 3 targets all processors.
- R2: Only implemented processors are targeted: list bits at or above NCPU are ignored. A request whose interrupt number is NID or more changes no state.
- R3: After reset every bitmap is empty and every `pend` bit is low. A request sets bit `sgi_src` in the bitmap of every target for that number. From the next cycle, `pend[cpu*NID+id]` is high for each of those targets.
- R4: An acknowledge for (`ack_cpu`, `ack_id`) raises `ack_rsp_valid` in the following cycle, and only then. The response is `ack_id` in bits 9:0 with the lowest set source in bits 12:10. The acknowledge clears only that one source bit.
- R5: An acknowledge of an empty bitmap returns 0x3FF and changes no state.
- R6: A `pend` bit stays high while any source remains in its bitmap. It falls in the cycle after the last source is removed.
- R7: A bitmap write with `bm_set`=1 ORs `bm_data` into the selected bitmap and makes it pending. A zero `bm_data` has no effect.
- R8: A bitmap write with `bm_set`=0 clears the bits of `bm_data` in the selected bitmap. The pending flag drops only if the bitmap becomes empty.
- R9: When a request and an acknowledge hit the same bitmap in one cycle, the acknowledge's clear is applied first and the request's set after it. The source that was just signalled is not lost.
- R10: `rd_bits` shows the current bitmap of (`rd_cpu`, `rd_id`) without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sgi_valid | input | 1 | Request beat strobe |
| sgi_src | input | CW | Requesting processor |
| sgi_word | input | 32 | Request word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CW | Acknowledging processor |
| ack_id | input | IW | Interrupt number acknowledged |
| ack_rsp_valid | output | 1 | Acknowledge result valid |
| ack_rsp_data | output | 13 | Source in 12:10, number in 9:0 |
| bm_valid | input | 1 | Bitmap write strobe |
| bm_cpu | input | CW | Processor owning the bitmap |
| bm_id | input | IW | Interrupt number of the bitmap |
| bm_set | input | 1 | 1 = OR bits in, 0 = clear bits |
| bm_data | input | NCPU | Source bits written |
| rd_cpu | input | CW | Read-back processor |
| rd_id | input | IW | Read-back interrupt number |
| rd_bits | output | NCPU | Bitmap read back |
| pend | output | NCPU*NID | Pending flag per processor and number |

## Verification
The hardest situation to reach from the ports is a request and an acknowledge landing on the same bitmap in the same cycle. This matters most when the incoming source is the one the acknowledge removes. The bench first loads that bitmap with a single source. It then drives both strobes in one cycle, once with the same source and once with a different one. It checks the response and reads the bitmap back afterwards. Draining every bitmap one acknowledge at a time forces the lowest-source order and the late fall of the pending flag to show at the ports.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_ALL    = 2'd3
  } sgi_filt_e;

  localparam int NUM_LSB   = 0;
  localparam int NUM_W     = 10;
  localparam int LIST_LSB  = 16;
  localparam int FLT_LSB   = 24;
  localparam int SRC_W     = 3;
  localparam int RSP_W     = NUM_W + SRC_W;
  localparam logic [RSP_W-1:0] RSP_NONE = RSP_W'(10'h3FF);
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
  import sgi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NID  = 16,
  parameter int CW   = 3,
  parameter int IW   = 4
) (
  input  logic            valid,
  input  logic [CW-1:0]   src,
  input  logic [31:0]     word,
  output logic            hit,
  output logic [IW-1:0]   id,
  output logic [NCPU-1:0] tmask
);
  logic [NUM_W-1:0] num;
  logic [NCPU-1:0]  self_m;
  logic [NCPU-1:0]  all_m;
  logic             unused_bits;

  assign num         = word[NUM_LSB +: NUM_W];
  assign all_m       = '1;
  assign self_m      = NCPU'(1) << src;
  assign hit         = valid && (num < NUM_W'(NID));
  assign id          = num[IW-1:0];
  assign unused_bits = ^{word[31:FLT_LSB+2], word[LIST_LSB-1:NUM_W], word[LIST_LSB+7:LIST_LSB]};

  always_comb begin
    unique case (sgi_filt_e'(word[FLT_LSB +: 2]))
      FLT_LIST:   tmask = word[LIST_LSB +: NCPU];
      FLT_OTHERS: tmask = all_m & ~self_m;
      FLT_SELF:   tmask = self_m;
      default:    tmask = all_m;
    endcase
  end
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
  parameter int NCPU = 8,
  parameter int CW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_hit,
  input  logic [CW-1:0]   req_src,
  input  logic            ack_hit,
  input  logic            wr_hit,
  input  logic            wr_set,
  input  logic [NCPU-1:0] wr_data,
  output logic [NCPU-1:0] bits
);
  logic [NCPU-1:0] lowest;
  logic [NCPU-1:0] nxt;

  assign lowest = bits & (~bits + NCPU'(1));

  always_comb begin
    nxt = bits;
    if (ack_hit)            nxt = nxt & ~lowest;
    if (wr_hit && !wr_set)  nxt = nxt & ~wr_data;
    if (wr_hit && wr_set)   nxt = nxt | wr_data;
    if (req_hit)            nxt = nxt | (NCPU'(1) << req_src);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= nxt;
  end
endmodule

// File: rtl/sgi_ack_resp.sv
module sgi_ack_resp
  import sgi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int CW   = 3,
  parameter int IW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  logic [IW-1:0]    ack_id,
  input  logic [NCPU-1:0]  sel_bits,
  output logic             rsp_valid,
  output logic [RSP_W-1:0] rsp_data
);
  logic [CW-1:0] src;

  always_comb begin
    src = '0;
    for (int k = NCPU - 1; k >= 0; k--) begin
      if (sel_bits[k]) src = CW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ack_valid;
      if (ack_valid) begin
        rsp_data <= (|sel_bits) ? {SRC_W'(src), NUM_W'(ack_id)} : RSP_NONE;
      end
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter  int NCPU = 8,
  parameter  int NID  = 16,
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW   = (NID > 1) ? $clog2(NID) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sgi_valid,
  input  logic [CW-1:0]        sgi_src,
  input  logic [31:0]          sgi_word,
  input  logic                 ack_valid,
  input  logic [CW-1:0]        ack_cpu,
  input  logic [IW-1:0]        ack_id,
  output logic                 ack_rsp_valid,
  output logic [RSP_W-1:0]     ack_rsp_data,
  input  logic                 bm_valid,
  input  logic [CW-1:0]        bm_cpu,
  input  logic [IW-1:0]        bm_id,
  input  logic                 bm_set,
  input  logic [NCPU-1:0]      bm_data,
  input  logic [CW-1:0]        rd_cpu,
  input  logic [IW-1:0]        rd_id,
  output logic [NCPU-1:0]      rd_bits,
  output logic [NCPU*NID-1:0]  pend
);
  localparam int NCELL = NCPU * NID;

  logic            dec_hit;
  logic [IW-1:0]   dec_id;
  logic [NCPU-1:0] dec_mask;
  logic [NCPU-1:0] cell_bits [NCELL];
  logic [NCPU-1:0] ack_sel;

  sgi_target_decode #(.NCPU(NCPU), .NID(NID), .CW(CW), .IW(IW)) u_dec (
    .valid (sgi_valid),
    .src   (sgi_src),
    .word  (sgi_word),
    .hit   (dec_hit),
    .id    (dec_id),
    .tmask (dec_mask)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar i = 0; i < NID; i++) begin : g_num
      localparam int K = c * NID + i;
      logic rh, ah, wh;
      assign rh = dec_hit && dec_mask[c] && (dec_id == IW'(i));
      assign ah = ack_valid && (ack_cpu == CW'(c)) && (ack_id == IW'(i));
      assign wh = bm_valid && (bm_cpu == CW'(c)) && (bm_id == IW'(i));

      sgi_src_cell #(.NCPU(NCPU), .CW(CW)) u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_hit (rh),
        .req_src (sgi_src),
        .ack_hit (ah),
        .wr_hit  (wh),
        .wr_set  (bm_set),
        .wr_data (bm_data),
        .bits    (cell_bits[K])
      );
      assign pend[K] = |cell_bits[K];
    end
  end

  always_comb begin
    ack_sel = '0;
    rd_bits = '0;
    if ((int'(ack_cpu) < NCPU) && (int'(ack_id) < NID))
      ack_sel = cell_bits[int'(ack_cpu) * NID + int'(ack_id)];
    if ((int'(rd_cpu) < NCPU) && (int'(rd_id) < NID))
      rd_bits = cell_bits[int'(rd_cpu) * NID + int'(rd_id)];
  end

  sgi_ack_resp #(.NCPU(NCPU), .CW(CW), .IW(IW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ack_id    (ack_id),
    .sel_bits  (ack_sel),
    .rsp_valid (ack_rsp_valid),
    .rsp_data  (ack_rsp_data)
  );
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
  import sgi_pkg::*;
#(
  parameter  int NCPU = 8,
  parameter  int NID  = 16,
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IW   = (NID > 1) ? $clog2(NID) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sgi_valid,
  input logic [CW-1:0]       sgi_src,
  input logic [31:0]         sgi_word,
  input logic                ack_valid,
  input logic [IW-1:0]       ack_id,
  input logic                ack_rsp_valid,
  input logic [RSP_W-1:0]    ack_rsp_data,
  input logic                bm_valid,
  input logic [CW-1:0]       bm_cpu,
  input logic [IW-1:0]       bm_id,
  input logic                bm_set,
  input logic [NCPU-1:0]     bm_data,
  input logic [NCPU*NID-1:0] pend
);
  logic self_ok, clr_ok;
  int   self_idx, clr_idx;
  logic unused_word;

  assign unused_word = ^{sgi_word[31:26], sgi_word[23:10]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      self_ok  <= 1'b0;
      clr_ok   <= 1'b0;
      self_idx <= 0;
      clr_idx  <= 0;
    end else begin
      self_ok  <= sgi_valid && (sgi_word[25:24] == 2'd2) &&
                  (sgi_word[9:0] < 10'(NID)) && (int'(sgi_src) < NCPU);
      self_idx <= int'(sgi_src) * NID + int'(sgi_word[IW-1:0]);
      clr_ok   <= bm_valid && !bm_set && (&bm_data) && !sgi_valid &&
                  (int'(bm_cpu) < NCPU) && (int'(bm_id) < NID);
      clr_idx  <= int'(bm_cpu) * NID + int'(bm_id);
    end
  end

  // R1
  self_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_ok |-> pend[self_idx]);

  // R4
  rsp_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_rsp_valid);

  // R4
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ack_rsp_valid);

  // R5
  rsp_number_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (ack_rsp_data[9:0] == 10'($past(ack_id))) || (ack_rsp_data == RSP_NONE));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |-> !pend[clr_idx]);

  // R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sgi_valid && !ack_valid && !bm_valid) |=> $stable(pend));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NID(NID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sgi_valid     (sgi_valid),
  .sgi_src       (sgi_src),
  .sgi_word      (sgi_word),
  .ack_valid     (ack_valid),
  .ack_id        (ack_id),
  .ack_rsp_valid (ack_rsp_valid),
  .ack_rsp_data  (ack_rsp_data),
  .bm_valid      (bm_valid),
  .bm_cpu        (bm_cpu),
  .bm_id         (bm_id),
  .bm_set        (bm_set),
  .bm_data       (bm_data),
  .pend          (pend)
);

// File: tb/sim_sgi_dispatch.sv
module sim_sgi_dispatch;
  localparam int NC = 4;
  localparam int NI = 8;
  localparam int CW = 2;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            sgi_valid, ack_valid, bm_valid, bm_set;
  logic [CW-1:0]   sgi_src, ack_cpu, bm_cpu, rd_cpu;
  logic [IW-1:0]   ack_id, bm_id, rd_id;
  logic [31:0]     sgi_word;
  logic [NC-1:0]   bm_data, rd_bits;
  logic            ack_rsp_valid;
  logic [12:0]     ack_rsp_data;
  logic [NC*NI-1:0] pend;

  sgi_dispatch #(.NCPU(NC), .NID(NI)) u0 (
    .clk(clk), .rst_n(rst_n),
    .sgi_valid(sgi_valid), .sgi_src(sgi_src), .sgi_word(sgi_word),
    .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_data(ack_rsp_data),
    .bm_valid(bm_valid), .bm_cpu(bm_cpu), .bm_id(bm_id), .bm_set(bm_set),
    .bm_data(bm_data), .rd_cpu(rd_cpu), .rd_id(rd_id), .rd_bits(rd_bits),
    .pend(pend)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NC-1:0] m [NC][NI];

  function automatic logic [31:0] mkw(int f, int list, int id);
    return {6'b0, 2'(f), 8'(list), 6'b0, 10'(id)};
  endfunction

  function automatic logic [NC-1:0] tmask(int src, logic [31:0] w);
    logic [NC-1:0] self_m = NC'(1) << src;
    case (w[25:24])
      2'd0:    return w[16 +: NC];
      2'd1:    return ~self_m;
      2'd2:    return self_m;
      default: return '1;
    endcase
  endfunction

  function automatic logic [31:0] pend_exp();
    logic [31:0] v = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++)
        v[c*NI+i] = |m[c][i];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pend(string req);
    chk(req, 32'(pend), pend_exp());
  endtask

  task automatic check_rd(int c, int i, string req);
    rd_cpu = CW'(c); rd_id = IW'(i);
    #1;
    chk(req, 32'(rd_bits), 32'(m[c][i]));
    @(negedge clk);
  endtask

  task automatic do_req(int src, logic [31:0] w);
    logic [NC-1:0] t = tmask(src, w);
    sgi_valid = 1'b1; sgi_src = CW'(src); sgi_word = w;
    @(negedge clk);
    sgi_valid = 1'b0;
    if (w[9:0] < NI)
      for (int c = 0; c < NC; c++)
        if (t[c]) m[c][w[IW-1:0]][src] = 1'b1;
  endtask

  function automatic logic [12:0] ack_exp(int c, int i);
    if (m[c][i] == 0) return 13'h3FF;
    for (int k = 0; k < NC; k++)
      if (m[c][i][k]) return {3'(k), 10'(i)};
    return 13'h3FF;
  endfunction

  function automatic logic [NC-1:0] drop_low(logic [NC-1:0] b);
    return b & (b - NC'(1));
  endfunction

  task automatic do_ack(int c, int i, string req);
    logic [12:0] e = ack_exp(c, i);
    ack_valid = 1'b1; ack_cpu = CW'(c); ack_id = IW'(i);
    @(negedge clk);
    ack_valid = 1'b0;
    chk(req, 32'(ack_rsp_valid), 32'd1);
    chk(req, 32'(ack_rsp_data), 32'(e));
    m[c][i] = drop_low(m[c][i]);
  endtask

  task automatic do_bm(int c, int i, bit set, logic [NC-1:0] d);
    bm_valid = 1'b1; bm_cpu = CW'(c); bm_id = IW'(i); bm_set = set; bm_data = d;
    @(negedge clk);
    bm_valid = 1'b0;
    if (set) m[c][i] = m[c][i] | d;
    else     m[c][i] = m[c][i] & ~d;
  endtask

  initial begin
    sgi_valid = 0; ack_valid = 0; bm_valid = 0; bm_set = 0;
    sgi_src = '0; ack_cpu = '0; bm_cpu = '0; rd_cpu = '0;
    ack_id = '0; bm_id = '0; rd_id = '0; sgi_word = '0; bm_data = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) m[c][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pend("R3 reset pend");
    chk("R4 reset rsp_valid", 32'(ack_rsp_valid), 32'd0);

    // R1 R2 R3: every requester under every filter, list with unimplemented bits
    for (int s = 0; s < NC; s++)
      for (int f = 0; f < 4; f++) begin
        do_req(s, mkw(f, ((s * 37 + 5) & 8'h0F) | 8'hA0, (s * 3 + f) % NI));
        check_pend("R1 R2 R3 filter sweep");
      end
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) check_rd(c, i, "R10 bitmap readback");

    // R2: out-of-range numbers
    do_req(1, mkw(3, 0, NI));
    do_req(2, mkw(0, 8'h0F, 10'h3F5));
    check_pend("R2 number out of range");

    // R4 R6: drain every bitmap one source at a time
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++)
        while (m[c][i] != 0) begin
          do_ack(c, i, "R4 ack lowest source");
          check_pend("R6 pend while draining");
        end
    do_ack(2, 5, "R5 empty ack");
    check_pend("R5 empty ack no change");

    // R7 R8: direct bitmap writes
    do_bm(1, 3, 1'b1, 4'b1010);
    check_pend("R7 set write pends");
    check_rd(1, 3, "R7 set bits");
    do_bm(1, 3, 1'b1, 4'b0000);
    check_rd(1, 3, "R7 zero set");
    do_bm(2, 4, 1'b1, 4'b0000);
    check_pend("R7 zero set no pend");
    do_ack(1, 3, "R4 source 1 first");
    check_rd(1, 3, "R4 only lowest cleared");
    do_bm(1, 3, 1'b0, 4'b0001);
    check_pend("R8 absent bit keeps pend");
    do_bm(1, 3, 1'b0, 4'b1000);
    check_pend("R8 last bit drops pend");
    check_rd(1, 3, "R8 bitmap empty");

    // R9: request and acknowledge on the same bitmap in one cycle
    do_req(0, mkw(2, 0, 6));
    ack_valid = 1'b1; ack_cpu = 2'd0; ack_id = 3'd6;
    sgi_valid = 1'b1; sgi_src = 2'd0; sgi_word = mkw(2, 0, 6);
    @(negedge clk);
    ack_valid = 1'b0; sgi_valid = 1'b0;
    chk("R9 same source ack data", 32'(ack_rsp_data), 32'({3'd0, 10'd6}));
    check_pend("R9 same source kept");
    check_rd(0, 6, "R9 same source bitmap");
    ack_valid = 1'b1; ack_cpu = 2'd0; ack_id = 3'd6;
    sgi_valid = 1'b1; sgi_src = 2'd3; sgi_word = mkw(0, 8'h01, 6);
    @(negedge clk);
    ack_valid = 1'b0; sgi_valid = 1'b0;
    m[0][6] = 4'b1000;
    chk("R9 other source ack data", 32'(ack_rsp_data), 32'({3'd0, 10'd6}));
    check_rd(0, 6, "R9 other source bitmap");
    check_pend("R9 other source pend");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule